// File: doc/BRIEF.md
# Strobed Local Bus Master Controller

This block is the master side of a synchronous execution bus on which every transfer is paced by two active-low strobes and closed by an active-low acknowledge from the addressed slave. A local client hands over one request at a time: a 24-bit address, a direction flag and, for writes, a 16-bit data word, qualified by a single-cycle start pulse. The controller then runs the whole bus transfer by itself and returns a one-cycle completion pulse. On reads, the completion pulse comes with the captured data. On a timeout it comes with an error flag instead.

A transfer has four phases. First the address and direction are driven with both strobes high. Next the address strobe goes low while the address is held. Then the data strobe goes low and the controller waits for the acknowledge. Last, both strobes are released. All intervals are counted in clock cycles: the setup count, the hold count, the write-data delay and the acknowledge timeout are inputs to the block. A slave may lower its acknowledge early, before the data strobe. The controller only acts on an acknowledge seen during the data phase. On a write, it also waits until its data has been on the lines for at least one cycle.

Top module: `strobe_bus_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes read 1, and the data output enable, busy, done and err all read 0.
- R2: An accepted start loads bus_addr and bus_wr (1 = write, 0 = read) from the request on the start edge. Both stay unchanged for as long as the address strobe is low.
- R3: bus_astb_n falls exactly cfg_setup+1 cycles after the edge that accepts the start.
- R4: bus_dstb_n falls exactly cfg_hold+1 cycles after bus_astb_n falls. The data strobe is never low while the address strobe is high.
- R5: On a write, bus_data_oe rises cfg_wdelay cycles after the data strobe falls, on the same edge when cfg_wdelay is 0, and bus_data_out then carries the request data. On a read, bus_data_oe stays 0.
- R6: bus_ack_n is acted on only in the data phase, so an acknowledge given during the address phase does not move any strobe edge. A write also needs its data to have been driven for one cycle. The edge that ends the transfer raises both strobes and drops bus_data_oe.
- R7: On a read, bus_data_in is captured on the ending edge. It appears on rd_data together with a done pulse that lasts exactly one cycle.
- R8: The timeout count T (cfg_timeout, taken as at least 1) starts when the data strobe falls. If no acknowledge ends the transfer within T edges, it is aborted on the T-th edge: strobes are released, done pulses and err is set. An acknowledge on that same edge wins, and the transfer ends without err. err stays set until the next accepted start clears it.
- R9: busy is 1 from the start edge until one full cycle after the strobes are released. A start pulse while busy is 1 is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | CNT_W | Address-to-address-strobe setup cycles |
| cfg_hold | input | CNT_W | Address-strobe-to-data-strobe cycles |
| cfg_wdelay | input | CNT_W | Data strobe to write data valid, cycles |
| cfg_timeout | input | TMO_W | Acknowledge timeout, cycles |
| req_start | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| busy | output | 1 | Transfer in progress, start not accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer aborted on timeout |
| rd_data | output | DW | Data captured by the last read |
| bus_addr | output | AW | Bus address lines |
| bus_wr | output | 1 | Bus direction status, 1 = write |
| bus_astb_n | output | 1 | Address strobe, active low |
| bus_dstb_n | output | 1 | Data strobe, active low |
| bus_ack_n | input | 1 | Slave acknowledge, active low |
| bus_data_in | input | DW | Data lines as driven by the slave |
| bus_data_out | output | DW | Data driven by the master |
| bus_data_oe | output | 1 | Enable for bus_data_out |

## Verification
The bench narrows the interval counters to CNT_W = 4 and TMO_W = 6. With those widths the largest setup and hold counts (15) can be exercised, so the saturating counters are driven to their ceiling. Short timeouts then let a single run cover a plain timeout and an abort that races an acknowledge arriving on the same edge. The rest of the width defaults are kept, so the 24-bit address and 16-bit data paths are checked at full size.

// File: rtl/strobe_bus_pkg.sv
package strobe_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_HOLD    = 3'd2,
        ST_DATA    = 3'd3,
        ST_RECOVER = 3'd4
    } sbm_state_e;

endpackage

// File: rtl/sbm_interval_cnt.sv
// Saturating cycle counter: cleared by clr, otherwise counts up to all ones.
module sbm_interval_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sbm_rd_capture.sv
// Read-return register: loads the bus data when cap is high.
module sbm_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = cap ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
    import strobe_bus_pkg::*;
#(
    parameter int AW    = 24,
    parameter int DW    = 16,
    parameter int CNT_W = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic [CNT_W-1:0] cfg_wdelay,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             req_start,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_wr,
    output logic             bus_astb_n,
    output logic             bus_dstb_n,
    input  logic             bus_ack_n,
    input  logic [DW-1:0]    bus_data_in,
    output logic [DW-1:0]    bus_data_out,
    output logic             bus_data_oe
);
    localparam int CNT_XW = CNT_W + 1;
    localparam int TMO_XW = TMO_W + 1;

    typedef struct packed {
        sbm_state_e     st;
        logic [AW-1:0]  addr;
        logic           wr;
        logic [DW-1:0]  wdata;
        logic           astb_n;
        logic           dstb_n;
        logic           oe;
        logic           done;
        logic           err;
    } regs_t;

    regs_t r_d, r_q;

    logic              ph_clr, tmo_clr, cap;
    logic [CNT_W-1:0]  ph_cnt;
    logic [TMO_W-1:0]  tmo_cnt;
    logic [CNT_XW-1:0] ph_next;
    logic [TMO_XW-1:0] tmo_next;
    logic              ack_seen;

    // Phase timer: restarts on every state change.
    sbm_interval_cnt #(.W(CNT_W)) u_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .cnt   (ph_cnt)
    );

    // Acknowledge timeout timer: runs only in the data phase.
    sbm_interval_cnt #(.W(TMO_W)) u_tmo_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmo_clr),
        .cnt   (tmo_cnt)
    );

    sbm_rd_capture #(.DW(DW)) u_rd_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (bus_data_in),
        .dout  (rd_data)
    );

    assign ph_next  = {1'b0, ph_cnt} + 1'b1;
    assign tmo_next = {1'b0, tmo_cnt} + 1'b1;
    assign ack_seen = !bus_ack_n;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cap      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_start) begin
                    r_d.st    = ST_SETUP;
                    r_d.addr  = req_addr;
                    r_d.wr    = req_write;
                    r_d.wdata = req_wdata;
                    r_d.err   = 1'b0;
                end
            end
            ST_SETUP: begin
                if (ph_cnt >= cfg_setup) begin
                    r_d.astb_n = 1'b0;
                    r_d.st     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ph_cnt >= cfg_hold) begin
                    r_d.dstb_n = 1'b0;
                    r_d.oe     = r_q.wr && (cfg_wdelay == '0);
                    r_d.st     = ST_DATA;
                end
            end
            ST_DATA: begin
                if (ack_seen && (!r_q.wr || r_q.oe)) begin
                    r_d.astb_n = 1'b1;
                    r_d.dstb_n = 1'b1;
                    r_d.oe     = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.st     = ST_RECOVER;
                    cap        = !r_q.wr;
                end else if (tmo_next >= {1'b0, cfg_timeout}) begin
                    r_d.astb_n = 1'b1;
                    r_d.dstb_n = 1'b1;
                    r_d.oe     = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.err    = 1'b1;
                    r_d.st     = ST_RECOVER;
                end else if (r_q.wr && (ph_next >= {1'b0, cfg_wdelay})) begin
                    r_d.oe = 1'b1;
                end
            end
            ST_RECOVER: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
        ph_clr  = (r_d.st != r_q.st);
        tmo_clr = (r_q.st != ST_DATA);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, wr: 1'b0, wdata: '0,
                     astb_n: 1'b1, dstb_n: 1'b1, oe: 1'b0,
                     done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign err          = r_q.err;
    assign bus_addr     = r_q.addr;
    assign bus_wr       = r_q.wr;
    assign bus_astb_n   = r_q.astb_n;
    assign bus_dstb_n   = r_q.dstb_n;
    assign bus_data_out = r_q.wdata;
    assign bus_data_oe  = r_q.oe;
endmodule

// File: rtl/strobe_bus_master_chk.sv
module strobe_bus_master_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_astb_n,
    input logic          bus_dstb_n,
    input logic          bus_data_oe
);
    // R2: address and direction hold while the address strobe stays low
    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_astb_n && !$past(bus_astb_n)) |-> ($stable(bus_addr) && $stable(bus_wr)));

    // R4: data strobe only inside the address strobe
    p_dstb_inside_astb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dstb_n |-> !bus_astb_n);

    // R5: master drives data only on writes during the data strobe
    p_oe_write_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (bus_wr && !bus_dstb_n));

    // R6: completion comes with both strobes released and data off
    p_release_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_astb_n && bus_dstb_n && !bus_data_oe));

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the error flag only rises together with a completion
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R9: one idle cycle with strobes high before busy drops
    p_busy_covers_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_astb_n && bus_dstb_n && !done));
endmodule

bind strobe_bus_master strobe_bus_master_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_astb_n  (bus_astb_n),
    .bus_dstb_n  (bus_dstb_n),
    .bus_data_oe (bus_data_oe)
);

// File: tb/tb_strobe_bus_master.sv
module tb_strobe_bus_master;
    localparam int AW    = 24;
    localparam int DW    = 16;
    localparam int CNT_W = 4;
    localparam int TMO_W = 6;

    // mode: 0 = ack a cycles after data strobe, 1 = ack from address strobe, 2 = never
    typedef struct packed {
        logic        wr;
        logic [3:0]  s;
        logic [3:0]  h;
        logic [3:0]  w;
        logic [1:0]  mode;
        logic [3:0]  a;
        logic [5:0]  t;
        logic [23:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd0,  4'd0,  4'd0, 2'd0, 4'd0,  6'd20, 24'hABCDE1, 16'h1234},
        '{1'b0, 4'd2,  4'd1,  4'd0, 2'd0, 4'd3,  6'd20, 24'h000010, 16'hBEEF},
        '{1'b1, 4'd3,  4'd2,  4'd4, 2'd0, 4'd0,  6'd20, 24'h5A5A5A, 16'hC3C3},
        '{1'b0, 4'd1,  4'd3,  4'd0, 2'd1, 4'd0,  6'd20, 24'hFFFFFF, 16'h0F0F},
        '{1'b1, 4'd1,  4'd1,  4'd1, 2'd1, 4'd0,  6'd20, 24'h123456, 16'hA5A5},
        '{1'b0, 4'd0,  4'd0,  4'd0, 2'd2, 4'd0,  6'd5,  24'h800000, 16'h7777},
        '{1'b1, 4'd15, 4'd15, 4'd2, 2'd2, 4'd0,  6'd9,  24'h00FF00, 16'h8001},
        '{1'b0, 4'd4,  4'd0,  4'd0, 2'd0, 4'd10, 6'd6,  24'h0000AA, 16'h4242},
        '{1'b1, 4'd0,  4'd1,  4'd0, 2'd0, 4'd5,  6'd6,  24'h3C3C3C, 16'h9999}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] cfg_setup, cfg_hold, cfg_wdelay;
    logic [TMO_W-1:0] cfg_timeout;
    logic             req_start, req_write;
    logic [AW-1:0]    req_addr;
    logic [DW-1:0]    req_wdata;
    logic             busy, done, err;
    logic [DW-1:0]    rd_data;
    logic [AW-1:0]    bus_addr;
    logic             bus_wr, bus_astb_n, bus_dstb_n, bus_ack_n;
    logic [DW-1:0]    bus_data_in, bus_data_out;
    logic             bus_data_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strobe_bus_master #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_wdelay(cfg_wdelay),
        .cfg_timeout(cfg_timeout),
        .req_start(req_start), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n), .bus_ack_n(bus_ack_n),
        .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx, input bit poke);
        int  c_astb, c_dstb, c_oe, c_done, c_idle, dcnt, d_edge, c_end, e_oe, abort_edge;
        bit  e_err, err_seen, addr_ok, data_ok, rel_ok;
        logic [DW-1:0] rd_seen;
        d_edge = int'(v.s) + int'(v.h) + 2;
        case (v.mode)
            2'd0:    c_end = d_edge + 1 + int'(v.a);
            2'd1:    c_end = d_edge + 1;
            default: c_end = 1000000;
        endcase
        if (v.mode != 2'd2 && v.wr && c_end < d_edge + int'(v.w) + 1)
            c_end = d_edge + int'(v.w) + 1;
        abort_edge = d_edge + ((v.t == 0) ? 1 : int'(v.t));
        e_err = 1'b0;
        if (abort_edge < c_end) begin
            c_end = abort_edge;
            e_err = 1'b1;
        end
        e_oe = (v.wr && (d_edge + int'(v.w) < c_end)) ? d_edge + int'(v.w) : -1;

        cfg_setup   = v.s;
        cfg_hold    = v.h;
        cfg_wdelay  = v.w;
        cfg_timeout = v.t;
        req_addr    = v.addr;
        req_write   = v.wr;
        req_wdata   = v.data;
        req_start   = 1'b1;
        @(negedge clk);
        req_start = 1'b0;

        chk(busy == 1'b1, "R9", $sformatf("vec%0d busy after start", idx), int'(busy), 1);
        chk(err == 1'b0, "R8", $sformatf("vec%0d err cleared by start", idx), int'(err), 0);

        c_astb = -1; c_dstb = -1; c_oe = -1; c_done = -1; c_idle = -1;
        dcnt = 0; addr_ok = 1'b1; data_ok = 1'b1; rel_ok = 1'b1;
        err_seen = 1'b0; rd_seen = '0;
        for (int k = 0; k < 150; k++) begin
            if (!bus_astb_n && c_astb < 0) c_astb = k;
            if (!bus_dstb_n && c_dstb < 0) c_dstb = k;
            if (!bus_astb_n && (bus_addr != v.addr || bus_wr != v.wr)) addr_ok = 1'b0;
            if (bus_data_oe && c_oe < 0) c_oe = k;
            if (bus_data_oe && bus_data_out != v.data) data_ok = 1'b0;
            if (done && c_done < 0) begin
                c_done   = k;
                err_seen = err;
                rd_seen  = rd_data;
                rel_ok   = bus_astb_n && bus_dstb_n && !bus_data_oe;
            end
            if (c_done >= 0 && !busy && c_idle < 0) c_idle = k;
            if (poke && k == 3) begin
                req_addr  = ~v.addr;
                req_write = ~v.wr;
                req_start = 1'b1;
            end else begin
                req_start = 1'b0;
            end
            if (!bus_dstb_n) dcnt++;
            case (v.mode)
                2'd0:    bus_ack_n = !(!bus_dstb_n && dcnt >= int'(v.a) + 1);
                2'd1:    bus_ack_n = bus_astb_n;
                default: bus_ack_n = 1'b1;
            endcase
            bus_data_in = !bus_dstb_n ? v.data : '0;
            if (c_idle >= 0) break;
            @(negedge clk);
        end
        req_start   = 1'b0;
        bus_ack_n   = 1'b1;
        bus_data_in = '0;

        chk(c_astb == int'(v.s) + 1, "R3", $sformatf("vec%0d address strobe cycle", idx),
            c_astb, int'(v.s) + 1);
        chk(c_dstb == d_edge, "R4", $sformatf("vec%0d data strobe cycle", idx), c_dstb, d_edge);
        chk(c_oe == e_oe, "R5", $sformatf("vec%0d data enable cycle", idx), c_oe, e_oe);
        chk(data_ok, "R5", $sformatf("vec%0d write data value", idx), int'(data_ok), 1);
        chk(addr_ok, "R2", $sformatf("vec%0d address/direction held", idx), int'(addr_ok), 1);
        chk(c_done == c_end, "R6", $sformatf("vec%0d end cycle", idx), c_done, c_end);
        chk(rel_ok, "R6", $sformatf("vec%0d release at end", idx), int'(rel_ok), 1);
        chk(err_seen == e_err, "R8", $sformatf("vec%0d err flag", idx), int'(err_seen), int'(e_err));
        if (!v.wr && !e_err)
            chk(rd_seen == v.data, "R7", $sformatf("vec%0d read data", idx),
                int'(rd_seen), int'(v.data));
        chk(c_idle == c_end + 1, "R9", $sformatf("vec%0d busy release", idx), c_idle, c_end + 1);

        if (poke) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk(!busy && bus_astb_n, "R9", $sformatf("start while busy queued, cycle %0d", k),
                    int'(busy), 0);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_setup = '0; cfg_hold = '0; cfg_wdelay = '0; cfg_timeout = 6'd10;
        req_start = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        bus_ack_n = 1'b1; bus_data_in = '0;
        repeat (3) @(negedge clk);
        chk(bus_astb_n && bus_dstb_n && !bus_data_oe, "R1", "strobes in reset",
            int'({bus_astb_n, bus_dstb_n, bus_data_oe}), 6);
        chk(!busy && !done && !err, "R1", "flags in reset", int'({busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_astb_n && bus_dstb_n && !bus_data_oe && !busy && !done && !err, "R1",
            "state after reset", int'({bus_astb_n, bus_dstb_n, bus_data_oe, busy, done, err}), 48);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i, 1'b0);
        end

        // R9: a start pulse during a transfer is ignored
        run_vec('{1'b1, 4'd2, 4'd2, 4'd1, 2'd0, 4'd2, 6'd20, 24'h0A0B0C, 16'h6C6C}, 100, 1'b1);
        // R6: early acknowledge on a read with long hold keeps the data strobe on schedule
        run_vec('{1'b0, 4'd0, 4'd7, 4'd0, 2'd1, 4'd0, 6'd1, 24'h000001, 16'hFACE}, 101, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule